// File: doc/BRIEF.md
# Clocked Serial Transfer Unit with Mode-Dependent Interrupt Requests

This block is a three-wire serial master. It has a serial clock output, a serial data output and a serial data input, and it transfers words of 8 to 16 bits. Software sets it up through a small register port that has four addresses: a control word, a transmit holding buffer, a receive holding buffer and a status word. The block raises two single-cycle interrupt requests. A done request means a word has completed or has landed in the receive buffer. A buffer-free request means the transmit holding buffer has been handed to the shifter and may be written again.

Which request fires depends on the transfer mode. The mode field has two bits: one enables reception and the other selects continuous operation.

In single modes, the done request marks the end of every transfer, including a transfer that only transmits. The buffer-free request never fires in single modes.

In continuous modes, the buffer-free request fires at each hand-off. If software refills the buffer before the current word ends, the next word follows with no idle gap.

A one-bit index output reports the highest-priority pending request, and the done request wins over the buffer-free request. An overrun flag records a received word that replaced one nobody had read.

Top module: `csio_irq_unit`

## Requirements
- R1: Register addresses are 0 for control, 1 for the transmit buffer, 2 for the receive buffer and 3 for status. After reset every register reads zero. Control and the transmit buffer read back as written. Status bits are bit0 overrun, bit1 busy, bit2 transmit-buffer-full and bit3 receive-buffer-full; its other bits read zero.
- R2: The word length L is 8 plus the control field in bits [7:4], limited to 16. Bits [L-1:0] of the transmit buffer go out on `sdo`, most significant bit first. `sdo` changes only when `sclk` falls, and `sdi` is sampled where `sclk` rises. Each word produces exactly L falling edges and L rising edges of `sclk`.
- R3: `sclk` idles high. While a transfer runs, every low phase and every high phase of `sclk` lasts H+1 system clock cycles, where H is control bits [15:8].
- R4: Control bits [1:0] select the mode: 0 single transmit, 1 single transmit/receive, 2 continuous transmit, 3 continuous transmit/receive. When bit0 is 1, each finished word is written into the receive buffer with zeros above bit L-1, receive-full is set, and `irq_rc` pulses. Reading address 2 clears receive-full.
- R5: In modes 0 and 1, `irq_rc` pulses once at the end of every word. In mode 0, the receive buffer and receive-full are left untouched.
- R6: In modes 2 and 3, `irq_te` pulses once each time the transmit buffer moves into the shifter. In modes 0 and 1, `irq_te` never pulses. Mode 2 raises no `irq_rc`.
- R7: In modes 2 and 3, if the transmit buffer holds a new word when the last bit of the current word is sampled, the next word starts without an idle gap. The high phase between the two words is H+1 cycles. Otherwise `sclk` stays high and busy drops.
- R8: Overrun is set when a received word lands while receive-full is still set and address 2 is not being read in that cycle. The new word replaces the old one, and `irq_rc` pulses. Overrun clears after a status read returns it, or after a write to address 3 with bit0 set. Such a write leaves receive-full unchanged.
- R9: `irq_any` is high when either request is high. `irq_hi` is 0 when `irq_rc` is high and 1 when only `irq_te` is high. A word end in mode 3 that chains into the next word raises both requests in the same cycle.
- R10: Status busy is high from the cycle after the transmit buffer is taken from idle until the last bit of a word with no follow-on is sampled. Each interrupt request is high for exactly one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe, for read side effects |
| addr | input | 2 | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational from `addr` |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq_rc | output | 1 | Done / receive-complete request pulse |
| irq_te | output | 1 | Transmit-buffer-free request pulse |
| irq_any | output | 1 | Either request active |
| irq_hi | output | 1 | Index of the highest-priority active request |

## Verification
The bench builds the block with its defaults: a 16-bit data width, an 8-bit half-period field and a minimum length of 8. This makes every length code from 0 to 9 reachable, so words of 8 through 16 bits and the saturation at 16 are all exercised. The bench sweeps all four modes against half-period codes 0, 1 and 2, with the serial output looped back to the input, inverted on alternate runs. Expected bit streams, phase lengths, buffer contents and request counts are derived arithmetically from the mode, length and data. Two further runs in continuous receive mode cover the gapless chained start, the coincident requests and both ways of clearing overrun.

// File: rtl/csio_pkg.sv
`timescale 1ns/1ps
package csio_pkg;

    // Mode field: bit0 enables reception, bit1 selects continuous operation.
    typedef enum logic [1:0] {
        MODE_SGL_TX   = 2'd0,
        MODE_SGL_TXRX = 2'd1,
        MODE_CNT_TX   = 2'd2,
        MODE_CNT_TXRX = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_TXBUF = 2'd1,
        A_RXBUF = 2'd2,
        A_STAT  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic rx_full;
        logic tx_full;
        logic busy;
        logic ovr;
    } stat_t;

    localparam int MODE_LSB = 0;
    localparam int WL_LSB   = 4;
    localparam int DIV_LSB  = 8;

    function automatic logic mode_cont(xfer_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_rx(xfer_mode_e m);
        return m[0];
    endfunction

    function automatic int unsigned word_len(int unsigned code, int unsigned lo, int unsigned hi);
        return (lo + code > hi) ? hi : lo + code;
    endfunction

endpackage

// File: rtl/csio_shift.sv
`timescale 1ns/1ps
module csio_shift
    import csio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  half,
    input  logic [CNT_W-1:0]  len,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_avail,
    input  logic              chain_en,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              busy,
    output logic              load,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);

    logic [DIV_W-1:0]  hcnt;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-1:0] sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] aligned;
    logic              tick;
    logic              rise;

    always_comb begin
        aligned = tx_word << (CNT_W'(DATA_W) - len);
        tick    = busy && (hcnt == half);
        rise    = tick && !sclk;
        done    = rise && (bitcnt == len - 1'b1);
        load    = (!busy && tx_avail) || (done && chain_en && tx_avail);
        rx_word = {rx_sh[DATA_W-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            sclk   <= 1'b1;
            sdo    <= 1'b0;
            hcnt   <= '0;
            bitcnt <= '0;
            sh     <= '0;
            rx_sh  <= '0;
        end else if (!busy) begin
            if (tx_avail) begin
                busy   <= 1'b1;
                sclk   <= 1'b0;
                sdo    <= aligned[DATA_W-1];
                sh     <= aligned << 1;
                hcnt   <= '0;
                bitcnt <= '0;
                rx_sh  <= '0;
            end
        end else begin
            hcnt <= tick ? '0 : hcnt + 1'b1;
            if (tick && sclk) begin
                sclk <= 1'b0;
                sdo  <= sh[DATA_W-1];
                sh   <= sh << 1;
            end
            if (rise) begin
                sclk  <= 1'b1;
                rx_sh <= rx_word;
                if (done) begin
                    bitcnt <= '0;
                    if (load) begin
                        sh    <= aligned;
                        rx_sh <= '0;
                    end else begin
                        busy <= 1'b0;
                    end
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R3: the serial clock rests high whenever no word is in flight
    p_idle_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk);

    // R2: the data line moves only together with a falling serial clock
    p_sdo_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $fell(sclk));

endmodule

// File: rtl/csio_irq_arb.sv
`timescale 1ns/1ps
module csio_irq_arb #(
    parameter int NREQ = 2,
    localparam int IDX_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Fixed priority: the lowest request index wins.
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    // R9: request 0 (done) always outranks the others
    p_low_index_wins_r9: assert property (@(posedge clk) disable iff (rst)
        req[0] |-> (any && idx == '0));

endmodule

// File: rtl/csio_irq_unit.sv
`timescale 1ns/1ps
module csio_irq_unit
    import csio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int WL_W   = 4,
    parameter int MIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              sclk,
    output logic              sdo,
    input  logic              sdi,
    output logic              irq_rc,
    output logic              irq_te,
    output logic              irq_any,
    output logic              irq_hi
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] ctrl_q, txbuf_q, rxbuf_q;
    logic              tx_full_q, rx_full_q, ovr_q;
    logic              irq_rc_q, irq_te_q;

    xfer_mode_e        mode;
    logic              cont;
    logic [WL_W-1:0]   wl;
    logic [DIV_W-1:0]  half;
    logic [CNT_W-1:0]  len;
    logic              wr_ctrl, wr_tx, wr_stat, rd_rx, rd_stat, rx_take;
    logic              sh_busy, sh_load, sh_done;
    logic [DATA_W-1:0] sh_rx;
    stat_t             stat;

    always_comb begin
        mode    = xfer_mode_e'(ctrl_q[MODE_LSB +: 2]);
        cont    = mode_cont(mode);
        wl      = ctrl_q[WL_LSB +: WL_W];
        half    = ctrl_q[DIV_LSB +: DIV_W];
        len     = CNT_W'(word_len(32'(wl), MIN_W, DATA_W));
        wr_ctrl = wr_en && (addr == A_CTRL);
        wr_tx   = wr_en && (addr == A_TXBUF);
        wr_stat = wr_en && (addr == A_STAT);
        rd_rx   = rd_en && (addr == A_RXBUF);
        rd_stat = rd_en && (addr == A_STAT);
        rx_take = sh_done && mode_rx(mode);
        stat    = '{rx_full: rx_full_q, tx_full: tx_full_q, busy: sh_busy, ovr: ovr_q};
        unique case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_TXBUF: rdata = txbuf_q;
            A_RXBUF: rdata = rxbuf_q;
            default: rdata = DATA_W'(stat);
        endcase
    end

    csio_shift #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .half     (half),
        .len      (len),
        .tx_word  (txbuf_q),
        .tx_avail (tx_full_q),
        .chain_en (cont),
        .sdi      (sdi),
        .sclk     (sclk),
        .sdo      (sdo),
        .busy     (sh_busy),
        .load     (sh_load),
        .done     (sh_done),
        .rx_word  (sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            txbuf_q   <= '0;
            rxbuf_q   <= '0;
            tx_full_q <= 1'b0;
            rx_full_q <= 1'b0;
            ovr_q     <= 1'b0;
            irq_rc_q  <= 1'b0;
            irq_te_q  <= 1'b0;
        end else begin
            irq_rc_q <= sh_done && (mode_rx(mode) || !cont);
            irq_te_q <= sh_load && cont;
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_tx) txbuf_q <= wdata;
            if (wr_tx) tx_full_q <= 1'b1;
            else if (sh_load) tx_full_q <= 1'b0;
            if (rx_take) begin
                rxbuf_q   <= sh_rx;
                rx_full_q <= 1'b1;
            end else if (rd_rx) begin
                rx_full_q <= 1'b0;
            end
            if (rx_take && rx_full_q && !rd_rx) ovr_q <= 1'b1;
            else if (rd_stat || (wr_stat && wdata[0])) ovr_q <= 1'b0;
        end
    end

    csio_irq_arb #(
        .NREQ (2)
    ) u_arb (
        .clk (clk),
        .rst (rst),
        .req ({irq_te_q, irq_rc_q}),
        .any (irq_any),
        .idx (irq_hi)
    );

    assign irq_rc = irq_rc_q;
    assign irq_te = irq_te_q;

    // R6: buffer-free requests only follow a cycle spent in a continuous mode
    p_te_cont_only_r6: assert property (@(posedge clk) disable iff (rst)
        irq_te_q |-> $past(cont));

    // R8: an overrun arrives together with a done request
    p_ovr_raises_rc_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> irq_rc_q);

    // R8: overrun needs an unread word already in the receive buffer
    p_ovr_after_full_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_q) |-> $past(rx_full_q));

    // R5: the end of a single-mode transfer always raises the done request
    p_single_end_rc_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(sh_busy) && !$past(cont)) |-> irq_rc_q);

endmodule

// File: tb/csio_irq_unit_bench.sv
`timescale 1ns/1ps
module csio_irq_unit_bench;
    import csio_pkg::*;

    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [1:0]    addr  = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          sclk, sdo, sdi, irq_rc, irq_te, irq_any, irq_hi;
    logic          inv = 1'b0;

    assign sdi = sdo ^ inv;

    csio_irq_unit u_csio_irq_unit (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .sclk    (sclk),
        .sdo     (sdo),
        .sdi     (sdi),
        .irq_rc  (irq_rc),
        .irq_te  (irq_te),
        .irq_any (irq_any),
        .irq_hi  (irq_hi)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    // serial-side monitor
    logic        prev_sclk = 1'b1;
    int          run_len = 0;
    bit          seen_edge = 1'b0;
    int          half_exp = 1;
    int          half_bad = 0;
    logic [31:0] cap = '0;
    int          n_rise = 0, n_fall = 0, n_rc = 0, n_te = 0, n_co = 0, prio_bad = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            summary();
            $finish;
        end
        if (!rst) begin
            if (sclk !== prev_sclk) begin
                if (seen_edge && run_len != half_exp) half_bad++;
                seen_edge = 1'b1;
                run_len = 1;
                if (sclk) begin
                    cap = {cap[30:0], sdo};
                    n_rise++;
                end else begin
                    n_fall++;
                end
            end else begin
                run_len++;
            end
            prev_sclk = sclk;
            if (irq_rc) n_rc++;
            if (irq_te) n_te++;
            if (irq_rc && irq_te) n_co++;
            if (irq_any !== (irq_rc | irq_te)) prio_bad++;
            if (irq_any && (irq_hi !== (irq_rc ? 1'b0 : 1'b1))) prio_bad++;
        end
    end

    task automatic clear_mon(input int h);
        half_exp  = h + 1;
        seen_edge = 1'b0;
        half_bad  = 0;
        cap       = '0;
        n_rise    = 0;
        n_fall    = 0;
        n_rc      = 0;
        n_te      = 0;
        n_co      = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        addr  = A_STAT;
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        addr  = A_STAT;
    endtask

    // addr rests on status, so rdata[1] shows busy without side effects
    task automatic wait_done(input string tag);
        int t;
        t = 0;
        while (rdata[1] !== 1'b1 && t < 300) begin
            @(negedge clk);
            t++;
        end
        while (rdata[1] !== 1'b0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(t > 0 && t < 3000, tag, 32'(t), 32'd3000);
    endtask

    logic [DW-1:0] tx, mask, got, exp_rx, last_rx, wa, wb;
    int            len;
    int            t;

    initial begin
        last_rx = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), got);
            chk_eq($sformatf("R1 reset read addr %0d", a), 32'(got), 32'd0);
        end
        chk_eq("R3 sclk idle after reset", 32'(sclk), 32'd1);
        chk_eq("R9 no request after reset", 32'({irq_rc, irq_te, irq_any}), 32'd0);

        // R1: control read-back
        wr(A_CTRL, 16'h5AF0);
        rd(A_CTRL, got);
        chk_eq("R1 control read-back", 32'(got), 32'h5AF0);

        // sweep: modes x half-period codes x length codes
        for (int m = 0; m < 4; m++) begin
            for (int h = 0; h < 3; h++) begin
                for (int w = 0; w < 10; w++) begin
                    len  = (8 + w > 16) ? 16 : 8 + w;
                    mask = (len == 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
                    tx   = 16'hB38D ^ (16'(w) * 16'h1357) ^ (16'(h) << 11) ^ 16'(m * 77);
                    inv  = 1'((w + h) & 1);
                    wr(A_CTRL, 16'((h << 8) | (w << 4) | m));
                    clear_mon(h);
                    wr(A_TXBUF, tx);
                    wait_done("R10 busy rises and falls");
                    chk_eq($sformatf("R2 bit stream m%0d h%0d w%0d", m, h, w),
                           32'(cap[15:0] & mask), 32'(tx & mask));
                    chk_eq("R2 rising edge count", 32'(n_rise), 32'(len));
                    chk_eq("R2 falling edge count", 32'(n_fall), 32'(len));
                    chk_eq($sformatf("R3 phase length errors h%0d", h), 32'(half_bad), 32'd0);
                    chk_eq("R3 sclk back high", 32'(sclk), 32'd1);
                    chk_eq($sformatf("R5 R10 done pulses mode %0d", m), 32'(n_rc), (m != 2) ? 32'd1 : 32'd0);
                    chk_eq($sformatf("R6 buffer-free pulses mode %0d", m), 32'(n_te), (m >= 2) ? 32'd1 : 32'd0);
                    if (m % 2 == 1) begin
                        exp_rx = (tx ^ (inv ? 16'hFFFF : 16'h0000)) & mask;
                        rd(A_STAT, got);
                        chk_eq("R4 status after receive", 32'(got), 32'h8);
                        rd(A_RXBUF, got);
                        chk_eq($sformatf("R4 received word len %0d", len), 32'(got), 32'(exp_rx));
                        last_rx = exp_rx;
                        rd(A_STAT, got);
                        chk_eq("R4 receive-full cleared by read", 32'(got), 32'h0);
                    end else begin
                        rd(A_STAT, got);
                        chk_eq("R5 R6 transmit-only leaves status clear", 32'(got), 32'h0);
                        rd(A_RXBUF, got);
                        chk_eq("R5 receive buffer untouched", 32'(got), 32'(last_rx));
                    end
                end
            end
        end

        // R7/R8/R9: chained continuous receive, overrun cleared by status read
        inv  = 1'b0;
        len  = 10;
        mask = 16'h03FF;
        wa   = 16'hF2C5;
        wb   = 16'h1E6B;
        wr(A_CTRL, 16'h0123);
        clear_mon(1);
        wr(A_TXBUF, wa);
        t = 0;
        while (n_te < 1 && t < 200) begin
            @(negedge clk);
            t++;
        end
        wr(A_TXBUF, wb);
        wait_done("R7 chained run ends");
        chk_eq("R7 two words back to back", cap[19:0], {12'd0, 10'(wa & mask), 10'(wb & mask)} & 32'hFFFFF);
        chk_eq("R7 falling edges over both words", 32'(n_fall), 32'd20);
        chk_eq("R7 no gap between words", 32'(half_bad), 32'd0);
        chk_eq("R6 two hand-offs", 32'(n_te), 32'd2);
        chk_eq("R4 two done pulses", 32'(n_rc), 32'd2);
        chk_eq("R9 coincident requests", 32'(n_co), 32'd1);
        rd(A_STAT, got);
        chk_eq("R8 overrun and full set", 32'(got), 32'h9);
        rd(A_RXBUF, got);
        chk_eq("R8 newer word kept", 32'(got), 32'(wb & mask));
        rd(A_STAT, got);
        chk_eq("R8 overrun cleared by status read", 32'(got), 32'h0);

        // R8: explicit clear by writing status
        clear_mon(1);
        wr(A_TXBUF, 16'h00A7);
        wait_done("R8 first word");
        wr(A_TXBUF, 16'h0359);
        wait_done("R8 second word");
        #1;
        chk_eq("R8 overrun set again", 32'(rdata), 32'h9);
        wr(A_STAT, 16'h0001);
        #1;
        chk_eq("R8 write clears overrun only", 32'(rdata), 32'h8);
        rd(A_RXBUF, got);
        chk_eq("R8 overwritten value", 32'(got), 32'h0359);
        chk_eq("R9 priority index and any flag", 32'(prio_bad), 32'd0);

        // R1: transmit buffer read-back
        rd(A_TXBUF, got);
        chk_eq("R1 transmit buffer read-back", 32'(got), 32'h0359);

        summary();
        $finish;
    end

endmodule